// File: doc/BRIEF.md
# Rotor Sandwich Vector Rotator

This block turns a three-dimensional vector by a rotor and returns the rotated vector. The rotor has a scalar part and three bivector parts, on the e1e2, e1e3 and e2e3 planes. The vector has three parts, on e1, e2 and e3. The block computes the sandwich product of the rotor, the vector and the rotor's reverse. The reverse keeps the scalar and negates the three bivector parts. Every value is a signed 32-bit Q16.16 word.

A single bank of ten multipliers does all of the arithmetic, in two passes. In the first pass it squares the rotor parts and forms their pairwise products. A small adder stage folds those ten products into the nine entries of the rotation matrix. In the second pass the same bank multiplies each matrix entry by the matching vector part, and one adder row per output sums the products.

The caller pulses a start strobe with the operands present. The caller then waits for a one-cycle done pulse, after which the result is held on the outputs.

Top module: `rotor_rotate`

## Requirements
- R1: While reset is asserted, and on leaving it, `done_o` is low and all three outputs are zero.
- R2: A rotor with scalar 1.0 (65536) and all bivector parts zero returns the input vector unchanged.
- R3: A rotor with scalar and e1e2 part both 46341 (about 0.7071) maps (x, y, z) to exactly (y, -x, z).
- R4: A rotor with scalar and e1e3 part both 46341 maps (x, y, z) to exactly (z, y, -x).
- R5: A rotor with scalar and e2e3 part both 46341 maps (x, y, z) to exactly (x, z, -y).
- R6: For any rotor (s, b12, b13, b23) the result matches the following model.
  - Every product is the full 64-bit signed product, shifted right arithmetically by 16 (a floor), and keeps its low 32 bits.
  - All sums and doublings wrap at 32 bits.
  - The matrix rows are [s²-b12²-b13²+b23², 2(s·b12-b13·b23), 2(s·b13+b12·b23)], [-2(s·b12+b13·b23), s²-b12²+b13²-b23², 2(s·b23-b12·b13)] and [2(b12·b23-s·b13), -2(s·b23+b12·b13), s²+b12²-b13²-b23²].
  - Output component r is the sum of row r times (x, y, z), with each product treated the same way.
- R7: If `start_i` is high in an idle cycle c, `done_o` is high for exactly one cycle, cycle c+7.
- R8: A start in cycles c+1 to c+6 is ignored. A start in the done cycle c+7 is accepted.
- R9: Operands are sampled only in the cycle in which a start is accepted. Later changes to the operand inputs do not affect that result.
- R10: The outputs change only in a cycle in which `done_o` is high. They hold their value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| rot_s_i | input | 32 | Rotor scalar part, Q16.16 |
| rot_b12_i | input | 32 | Rotor e1e2 part, Q16.16 |
| rot_b13_i | input | 32 | Rotor e1e3 part, Q16.16 |
| rot_b23_i | input | 32 | Rotor e2e3 part, Q16.16 |
| vec_x_i | input | 32 | Vector e1 part, Q16.16 |
| vec_y_i | input | 32 | Vector e2 part, Q16.16 |
| vec_z_i | input | 32 | Vector e3 part, Q16.16 |
| done_o | output | 1 | One-cycle result strobe |
| out_x_o | output | 32 | Rotated e1 part |
| out_y_o | output | 32 | Rotated e2 part |
| out_z_o | output | 32 | Rotated e3 part |

## Verification
The assertions assume the following about the inputs:
- `start_i` and the operand inputs are synchronous and settle before each rising edge.
- Reset is applied before the first start.
- The rotor is not required to be normalised, and the arithmetic is defined for every 32-bit pattern.

The stimulus changes every input only on falling clock edges. It raises start only as one-cycle pulses or as a deliberate stray pulse during a busy window. It mixes exact unit rotors with unnormalised and overflowing operands, so the wrap-around arithmetic stays inside the model the assertions rely on.

// File: rtl/rotor_pkg.sv
package rotor_pkg;

    localparam int NUM_LANES = 10;
    localparam int NUM_COEF  = 9;
    localparam int ROT_TERMS = 4;
    localparam int VEC_DIM   = 3;

    // phase-one lane contents: squares first, then pairwise products
    localparam int LN_SS   = 0;
    localparam int LN_11   = 1;
    localparam int LN_22   = 2;
    localparam int LN_33   = 3;
    localparam int LN_S1   = 4;
    localparam int LN_S2   = 5;
    localparam int LN_S3   = 6;
    localparam int LN_12   = 7;
    localparam int LN_13   = 8;
    localparam int LN_23   = 9;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_MUL1  = 3'd1,
        PH_WAIT1 = 3'd2,
        PH_COEF  = 3'd3,
        PH_MUL2  = 3'd4,
        PH_WAIT2 = 3'd5,
        PH_SUM   = 3'd6
    } rot_phase_e;

    // rotor term index (0 scalar, 1 e12, 2 e13, 3 e23) feeding the left side of a lane
    function automatic logic [1:0] lane_lhs(input int lane);
        case (lane)
            0, 4, 5, 6: return 2'd0;
            1, 7, 8:    return 2'd1;
            2, 9:       return 2'd2;
            default:    return 2'd3;
        endcase
    endfunction

    function automatic logic [1:0] lane_rhs(input int lane);
        case (lane)
            0:          return 2'd0;
            1, 4:       return 2'd1;
            2, 5, 7:    return 2'd2;
            default:    return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/rotor_mul_bank.sv
module rotor_mul_bank
    import rotor_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int FRAC_W = 16,
    parameter int LANES  = NUM_LANES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  logic [LANES-1:0][WORD_W-1:0]  lhs_i,
    input  logic [LANES-1:0][WORD_W-1:0]  rhs_i,
    output logic [LANES-1:0][WORD_W-1:0]  prod_o
);

    localparam int DW = 2 * WORD_W;

    logic [LANES-1:0][DW-1:0]     raw_d, raw_q;
    logic [LANES-1:0][WORD_W-1:0] scl_d, scl_q;
    logic                         vld_d, vld_q;

    // stage one: full-width signed product; stage two: Q-format rescale with floor
    always_comb begin
        vld_d = load_i;
        for (int k = 0; k < LANES; k++) begin
            raw_d[k] = load_i
                ? DW'($signed({{WORD_W{lhs_i[k][WORD_W-1]}}, lhs_i[k]})
                    * $signed({{WORD_W{rhs_i[k][WORD_W-1]}}, rhs_i[k]}))
                : raw_q[k];
            scl_d[k] = vld_q ? WORD_W'($signed(raw_q[k]) >>> FRAC_W) : scl_q[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
            scl_q <= '0;
            vld_q <= 1'b0;
        end else begin
            raw_q <= raw_d;
            scl_q <= scl_d;
            vld_q <= vld_d;
        end
    end

    assign prod_o = scl_q;

    // R9: a lane keeps its product unless the controller loads new operands
    a_r9_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(raw_q));

    // R7: the rescaled output moves only one cycle after a load
    a_r7_bank_stage: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_q) |-> $past(load_i, 2));

endmodule

// File: rtl/rotor_coef.sv
module rotor_coef
    import rotor_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [NUM_LANES-1:0][WORD_W-1:0] prod_i,
    output logic [NUM_COEF-1:0][WORD_W-1:0]  coef_o
);

    function automatic logic [WORD_W-1:0] twice(input logic [WORD_W-1:0] x);
        return x << 1;
    endfunction

    logic [WORD_W-1:0] ss, t11, t22, t33, s1, s2, s3, p12, p13, p23;

    assign ss  = prod_i[LN_SS];
    assign t11 = prod_i[LN_11];
    assign t22 = prod_i[LN_22];
    assign t33 = prod_i[LN_33];
    assign s1  = prod_i[LN_S1];
    assign s2  = prod_i[LN_S2];
    assign s3  = prod_i[LN_S3];
    assign p12 = prod_i[LN_12];
    assign p13 = prod_i[LN_13];
    assign p23 = prod_i[LN_23];

    // row-major 3x3 matrix, entry r*3+c multiplies vector part c into output r
    assign coef_o[0] = ss - t11 - t22 + t33;
    assign coef_o[1] = twice(s1 - p23);
    assign coef_o[2] = twice(s2 + p13);
    assign coef_o[3] = -twice(s1 + p23);
    assign coef_o[4] = ss - t11 + t22 - t33;
    assign coef_o[5] = twice(s3 - p12);
    assign coef_o[6] = twice(p13 - s2);
    assign coef_o[7] = -twice(s3 + p12);
    assign coef_o[8] = ss + t11 - t22 - t33;

endmodule

// File: rtl/rotor_rotate.sv
module rotor_rotate
    import rotor_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] rot_s_i,
    input  logic [WORD_W-1:0] rot_b12_i,
    input  logic [WORD_W-1:0] rot_b13_i,
    input  logic [WORD_W-1:0] rot_b23_i,
    input  logic [WORD_W-1:0] vec_x_i,
    input  logic [WORD_W-1:0] vec_y_i,
    input  logic [WORD_W-1:0] vec_z_i,
    output logic              done_o,
    output logic [WORD_W-1:0] out_x_o,
    output logic [WORD_W-1:0] out_y_o,
    output logic [WORD_W-1:0] out_z_o
);

    localparam int NL = NUM_LANES;
    localparam int NC = NUM_COEF;

    typedef struct packed {
        rot_phase_e                          st;
        logic [ROT_TERMS-1:0][WORD_W-1:0]    rot;
        logic [VEC_DIM-1:0][WORD_W-1:0]      vec;
        logic [NC-1:0][WORD_W-1:0]           coef;
        logic [VEC_DIM-1:0][WORD_W-1:0]      res;
        logic                                done;
    } rot_state_t;

    rot_state_t r_d, r_q;

    logic [NL-1:0][WORD_W-1:0] lhs_w, rhs_w, prod_w;
    logic [NC-1:0][WORD_W-1:0] coef_w;
    logic                      bank_load_w;
    logic                      pass2_w;

    assign bank_load_w = (r_q.st == PH_MUL1) || (r_q.st == PH_MUL2);
    assign pass2_w     = (r_q.st == PH_MUL2);

    // lane operand steering: rotor pairs in pass one, matrix entry times vector part in pass two
    for (genvar g = 0; g < NL; g++) begin : g_lane
        localparam logic [1:0] LSEL = lane_lhs(g);
        localparam logic [1:0] RSEL = lane_rhs(g);
        if (g < NC) begin : g_shared
            localparam logic [1:0] COL = 2'(g % VEC_DIM);
            assign lhs_w[g] = pass2_w ? r_q.coef[g]  : r_q.rot[LSEL];
            assign rhs_w[g] = pass2_w ? r_q.vec[COL] : r_q.rot[RSEL];
        end else begin : g_pass1
            assign lhs_w[g] = pass2_w ? '0 : r_q.rot[LSEL];
            assign rhs_w[g] = pass2_w ? '0 : r_q.rot[RSEL];
        end
    end

    rotor_mul_bank #(
        .WORD_W (WORD_W),
        .FRAC_W (FRAC_W),
        .LANES  (NL)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (bank_load_w),
        .lhs_i  (lhs_w),
        .rhs_i  (rhs_w),
        .prod_o (prod_w)
    );

    rotor_coef #(
        .WORD_W (WORD_W)
    ) u_coef (
        .prod_i (prod_w),
        .coef_o (coef_w)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            PH_IDLE: begin
                if (start_i) begin
                    r_d.rot = {rot_b23_i, rot_b13_i, rot_b12_i, rot_s_i};
                    r_d.vec = {vec_z_i, vec_y_i, vec_x_i};
                    r_d.st  = PH_MUL1;
                end
            end
            PH_MUL1:  r_d.st = PH_WAIT1;
            PH_WAIT1: r_d.st = PH_COEF;
            PH_COEF: begin
                r_d.coef = coef_w;
                r_d.st   = PH_MUL2;
            end
            PH_MUL2:  r_d.st = PH_WAIT2;
            PH_WAIT2: r_d.st = PH_SUM;
            PH_SUM: begin
                r_d.res[0] = prod_w[0] + prod_w[1] + prod_w[2];
                r_d.res[1] = prod_w[3] + prod_w[4] + prod_w[5];
                r_d.res[2] = prod_w[6] + prod_w[7] + prod_w[8];
                r_d.done   = 1'b1;
                r_d.st     = PH_IDLE;
            end
            default:  r_d.st = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o  = r_q.done;
    assign out_x_o = r_q.res[0];
    assign out_y_o = r_q.res[1];
    assign out_z_o = r_q.res[2];

    // R7: done lasts a single cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: the summing phase is always followed by done, and done has no other source
    a_r7_done_after_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == PH_SUM) |=> done_o);
    a_r7_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(r_q.st == PH_SUM));

    // R8: a busy unit never restarts its first pass
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != PH_IDLE) |=> (r_q.st != PH_MUL1));

    // R9: captured operands stay frozen while a rotation is in flight
    a_r9_operands_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != PH_IDLE) |=> ($stable(r_q.rot) && $stable(r_q.vec)));

    // R10: results move only together with done
    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({out_x_o, out_y_o, out_z_o}) |-> done_o);

endmodule

// File: tb/test_rotor_rotate.sv
module test_rotor_rotate;

    localparam int CLK_PERIOD = 10;
    localparam int ONE  = 65536;
    localparam int HALF_SQRT2 = 46341;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] q0 = '0, q1 = '0, q2 = '0, q3 = '0;
    logic [31:0] a1 = '0, a2 = '0, a3 = '0;
    logic        done;
    logic [31:0] v1, v2, v3;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rotor_rotate i_rotor_rotate (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .rot_s_i   (q0),
        .rot_b12_i (q1),
        .rot_b13_i (q2),
        .rot_b23_i (q3),
        .vec_x_i   (a1),
        .vec_y_i   (a2),
        .vec_z_i   (a3),
        .done_o    (done),
        .out_x_o   (v1),
        .out_y_o   (v2),
        .out_z_o   (v3)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Q16.16 product, floor rounding, low 32 bits kept
    function automatic int fx(input int x, input int y);
        longint p;
        p = longint'(x) * longint'(y);
        return int'(p >>> 16);
    endfunction

    // symbolic expansion of R v R~ with the reverse negating every bivector term
    function automatic void expand(input int s, input int b12, input int b13, input int b23,
                                   input int x, input int y, input int z,
                                   output int ox, output int oy, output int oz);
        int m11, m12, m13, m21, m22, m23, m31, m32, m33;
        m11 = fx(s, s) - fx(b12, b12) - fx(b13, b13) + fx(b23, b23);
        m22 = fx(s, s) - fx(b12, b12) + fx(b13, b13) - fx(b23, b23);
        m33 = fx(s, s) + fx(b12, b12) - fx(b13, b13) - fx(b23, b23);
        m12 = 2 * (fx(s, b12) - fx(b13, b23));
        m21 = -2 * (fx(s, b12) + fx(b13, b23));
        m13 = 2 * (fx(s, b13) + fx(b12, b23));
        m31 = 2 * (fx(b12, b23) - fx(s, b13));
        m23 = 2 * (fx(s, b23) - fx(b12, b13));
        m32 = -2 * (fx(s, b23) + fx(b12, b13));
        ox = fx(m11, x) + fx(m12, y) + fx(m13, z);
        oy = fx(m21, x) + fx(m22, y) + fx(m23, z);
        oz = fx(m31, x) + fx(m32, y) + fx(m33, z);
    endfunction

    // cycle-level reference: countdown per accepted start, expected outputs per cycle
    int cnt = 0;
    bit e_done = 1'b0;
    int e1 = 0, e2 = 0, e3 = 0;
    int p1 = 0, p2 = 0, p3 = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            cnt = 0; e_done = 1'b0; e1 = 0; e2 = 0; e3 = 0;
        end else begin
            e_done = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    e_done = 1'b1; e1 = p1; e2 = p2; e3 = p3;
                end
            end else if (start) begin
                cnt = 6;
                expand(q0, q1, q2, q3, a1, a2, a3, p1, p2, p3);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R7 done timing vs model", int'(done), int'(e_done));
            check("R6/R10 x vs model", $signed(v1), e1);
            check("R6/R10 y vs model", $signed(v2), e2);
            check("R6/R10 z vs model", $signed(v3), e3);
        end
    end

    task automatic set_ops(input int s, input int b12, input int b13, input int b23,
                           input int x, input int y, input int z);
        q0 = s; q1 = b12; q2 = b13; q3 = b23; a1 = x; a2 = y; a3 = z;
    endtask

    task automatic launch(input int s, input int b12, input int b13, input int b23,
                          input int x, input int y, input int z);
        @(negedge clk);
        set_ops(s, b12, b13, b23, x, y, z);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 1;
        while (done !== 1'b1 && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_vec(input string tag, input int x, input int y, input int z);
        check({tag, " x"}, $signed(v1), x);
        check({tag, " y"}, $signed(v2), y);
        check({tag, " z"}, $signed(v3), z);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R7 watchdog: actual no completion expected completion");
            finish_run();
        end
    end

    initial begin
        int lat;
        int ex, ey, ez;
        int hx, hy, hz;

        repeat (3) @(negedge clk);
        check("R1 done in reset", int'(done), 0);
        check_vec("R1 outputs in reset", 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", int'(done), 0);
        check_vec("R1 outputs after reset", 0, 0, 0);

        // R2: identity rotor
        launch(ONE, 0, 0, 0, 212992, -491520, 6553600);
        wait_done(lat);
        check("R7 latency identity", lat, 7);
        check_vec("R2 identity", 212992, -491520, 6553600);

        // R3: quarter turn in the e1e2 plane
        launch(HALF_SQRT2, HALF_SQRT2, 0, 0, 327680, -81920, 131072);
        wait_done(lat);
        check("R7 latency e12", lat, 7);
        check_vec("R3 e12 quarter", -81920, -327680, 131072);

        // R4: quarter turn in the e1e3 plane
        launch(HALF_SQRT2, 0, HALF_SQRT2, 0, 327680, -81920, 131072);
        wait_done(lat);
        check_vec("R4 e13 quarter", 131072, -81920, -327680);

        // R5: quarter turn in the e2e3 plane
        launch(HALF_SQRT2, 0, 0, HALF_SQRT2, 327680, -81920, 131072);
        wait_done(lat);
        check_vec("R5 e23 quarter", 327680, 131072, 81920);

        // R6: general unnormalised rotor
        launch(58982, 6554, -19661, 13107, 98304, -131072, 49152);
        wait_done(lat);
        expand(58982, 6554, -19661, 13107, 98304, -131072, 49152, ex, ey, ez);
        check_vec("R6 general rotor", ex, ey, ez);

        // R6: operands large enough to wrap intermediate sums
        launch(1073741824, -123456789, 987654321, 5, 7, -2000000000, 123);
        wait_done(lat);
        expand(1073741824, -123456789, 987654321, 5, 7, -2000000000, 123, ex, ey, ez);
        check_vec("R6 wrapping rotor", ex, ey, ez);

        // R8: stray start while busy is dropped, start in the done cycle is taken
        launch(ONE, 0, 0, 0, ONE, 2 * ONE, 3 * ONE);
        @(negedge clk);
        @(negedge clk);
        set_ops(HALF_SQRT2, HALF_SQRT2, 0, 0, 5 * ONE, 6 * ONE, 7 * ONE);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(lat);
        check("R8 busy start ignored, first done latency", lat, 4);
        check_vec("R8 first result kept", ONE, 2 * ONE, 3 * ONE);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7 done is one cycle", int'(done), 0);
        wait_done(lat);
        check("R8 start in done cycle latency", lat, 7);
        check_vec("R8 start in done cycle result", 6 * ONE, -5 * ONE, 7 * ONE);

        // R9: operand changes after acceptance have no effect
        launch(HALF_SQRT2, 0, 0, HALF_SQRT2, 4 * ONE, 8 * ONE, -ONE);
        set_ops(12345, -54321, 999, 7, 1, 2, 3);
        @(negedge clk);
        set_ops(-ONE, ONE, ONE, ONE, -9, -9, -9);
        wait_done(lat);
        check_vec("R9 operands frozen", 4 * ONE, -ONE, -8 * ONE);

        // R10: outputs hold without a start while inputs wander
        hx = $signed(v1); hy = $signed(v2); hz = $signed(v3);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            set_ops(i * 1000, -i, i, 3 * i, i, i + 1, i + 2);
        end
        check_vec("R10 outputs held", hx, hy, hz);
        check("R10 no done without start", int'(done), 0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule